// File: doc/BRIEF.md
# Dual-Source GPIO Port Resolver

A sixteen-pin general-purpose I/O port whose pin levels are worked out from three sources: the CPU's data register (where the CPU holds the pin as an output), a peripheral-side driver pair (direction and data), and a per-pin pull-up. The CPU configures the port through one 32-bit control word and one 16-bit data word. Reading the data word returns the resolved pin levels, not the stored CPU data.

Every CPU write to either word is checked for its effect on the pins. When the levels change, the block sends a one-cycle notification to each attached client whose trigger mask touches a changed pin. The notification carries the new levels and the set of changed pins. A client that reacts by updating the peripheral-side driver triggers one more evaluation. A small state machine handles this. `IDLE` is the normal state. The transition `IDLE -> REEVAL` is taken on a peripheral update with no CPU write in the same cycle. In `REEVAL`, the levels from before that update are compared with the levels after the cycle's writes. The transition `REEVAL -> IDLE` is always taken after one cycle.

Top module: `gpio_port_resolver`

## Requirements
- R1: In the control word, bit 2n is the CPU direction of pin n (1 = CPU drives) and bit 2n+1 enables the pull-up of pin n.
- R2: Pin n resolves to (cpu_dir & cpu_data) | (per_dir & per_data) | (~(cpu_dir | per_dir) & pullup), and `dat_rdata` always shows the resolved levels of the current register contents.
- R3: A data write to a pin the CPU does not drive does not alter that pin's level. The stored value appears once the pin's direction bit is set.
- R4: After reset, all registers and masks are zero, `dat_rdata` is 0 and no notification is pending.
- R5: For a CPU write in `IDLE`, the cycle after the write edge shows `evt_changed` = old XOR new levels and `evt_levels` = new levels. These two outputs hold until the next notification.
- R6: A write that leaves the resolved levels unchanged raises no `evt_valid` bit.
- R7: `evt_valid[i]` is high for exactly one cycle, and only if client i's trigger mask (as it stood at the write edge) overlaps the changed set. Writing a mask raises no notification.
- R8: A peripheral update alone in `IDLE` moves the state to `REEVAL`. It produces no notification in the next cycle. The cycle after that notifies on the levels from before the update compared with the levels after it.
- R9: A peripheral update in the same cycle as a CPU write is folded into that write's single notification, issued the next cycle, with no re-evaluation afterwards.
- R10: A CPU write during `REEVAL` is compared against the levels from before the peripheral update, and the state returns to `IDLE`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_wr | input | 1 | Control-word write strobe |
| ctl_wdata | input | 32 | Control word (interleaved direction / pull-up) |
| dat_wr | input | 1 | Data-word write strobe |
| dat_wdata | input | 16 | CPU output data |
| dat_rdata | output | 16 | Resolved pin levels |
| per_wr | input | 1 | Peripheral-side driver update strobe |
| per_dir | input | 16 | Peripheral-side direction (1 = drives) |
| per_data | input | 16 | Peripheral-side output data |
| mask_wr | input | 1 | Trigger-mask write strobe |
| mask_sel | input | 2 | Client slot selected for the mask write |
| mask_wdata | input | 16 | Trigger mask value |
| evt_valid | output | 4 | Per-client one-cycle notification |
| evt_levels | output | 16 | Levels after the last notified change |
| evt_changed | output | 16 | Pins changed in the last notification |

## Verification
The bench builds the block at its defaults: sixteen pins and four client slots. At this size, a model of every register fits in plain bench variables, and full-width random control words reach every combination of direction, pull-up and peripheral drive on each pin. Four clients with partly overlapping masks allow cases where one change notifies some clients and not others. The directed cases place a peripheral update alone, together with a CPU write, and followed by a CPU write, which exercises both state transitions and the folded case.

// File: rtl/gpio_res_pkg.sv
package gpio_res_pkg;
    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_REEVAL = 1'b1
    } res_state_t;
endpackage

// File: rtl/gpio_ctl_split.sv
module gpio_ctl_split #(
    parameter int NPINS = 16
) (
    input  logic [2*NPINS-1:0] ctl,
    output logic [NPINS-1:0]   dir,
    output logic [NPINS-1:0]   pup
);
    for (genvar n = 0; n < NPINS; n++) begin : g_pin
        assign dir[n] = ctl[2*n];
        assign pup[n] = ctl[2*n+1];
    end
endmodule

// File: rtl/gpio_level_resolve.sv
module gpio_level_resolve #(
    parameter int NPINS = 16
) (
    input  logic [NPINS-1:0] cpu_dir,
    input  logic [NPINS-1:0] cpu_dat,
    input  logic [NPINS-1:0] per_dir,
    input  logic [NPINS-1:0] per_dat,
    input  logic [NPINS-1:0] pup,
    output logic [NPINS-1:0] lv
);
    // Each pin: OR of both active drivers, pull-up only when nobody drives.
    assign lv = (cpu_dir & cpu_dat)
              | (per_dir & per_dat)
              | (~(cpu_dir | per_dir) & pup);
endmodule

// File: rtl/gpio_evt_fsm.sv
module gpio_evt_fsm
    import gpio_res_pkg::*;
#(
    parameter int NPINS    = 16,
    parameter int NCLIENTS = 4
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           bus_wr,
    input  logic                           per_wr,
    input  logic [NPINS-1:0]               cur_lv,
    input  logic [NPINS-1:0]               nxt_lv,
    input  logic [NCLIENTS-1:0][NPINS-1:0] mask,
    output res_state_t                     st,
    output logic [NCLIENTS-1:0]            evt_valid,
    output logic [NPINS-1:0]               evt_levels,
    output logic [NPINS-1:0]               evt_changed
);
    res_state_t        st_q, st_d;
    logic [NPINS-1:0]  snap_q;
    logic              emit;
    logic              capture;
    logic [NPINS-1:0]  old_lv;
    logic [NPINS-1:0]  diff;
    logic [NCLIENTS-1:0] hit;

    always_comb begin
        st_d    = st_q;
        emit    = 1'b0;
        capture = 1'b0;
        old_lv  = cur_lv;
        unique case (st_q)
            ST_IDLE: begin
                if (bus_wr) begin
                    emit = 1'b1;
                end else if (per_wr) begin
                    capture = 1'b1;
                    st_d    = ST_REEVAL;
                end
            end
            ST_REEVAL: begin
                emit   = 1'b1;
                old_lv = snap_q;
                st_d   = ST_IDLE;
            end
        endcase
    end

    assign diff = old_lv ^ nxt_lv;

    for (genvar i = 0; i < NCLIENTS; i++) begin : g_hit
        assign hit[i] = |(mask[i] & diff);
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= ST_IDLE;
            snap_q <= '0;
        end else begin
            st_q <= st_d;
            if (capture) snap_q <= cur_lv;
        end
    end

    // notification outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            evt_valid   <= '0;
            evt_levels  <= '0;
            evt_changed <= '0;
        end else begin
            evt_valid <= '0;
            if (emit && (diff != '0)) begin
                evt_valid   <= hit;
                evt_levels  <= nxt_lv;
                evt_changed <= diff;
            end
        end
    end

    assign st = st_q;
endmodule

// File: rtl/gpio_port_resolver.sv
module gpio_port_resolver
    import gpio_res_pkg::*;
#(
    parameter int NPINS    = 16,
    parameter int NCLIENTS = 4,
    localparam int CW      = 2 * NPINS,
    localparam int SELW    = (NCLIENTS > 1) ? $clog2(NCLIENTS) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ctl_wr,
    input  logic [CW-1:0]       ctl_wdata,
    input  logic                dat_wr,
    input  logic [NPINS-1:0]    dat_wdata,
    output logic [NPINS-1:0]    dat_rdata,
    input  logic                per_wr,
    input  logic [NPINS-1:0]    per_dir,
    input  logic [NPINS-1:0]    per_data,
    input  logic                mask_wr,
    input  logic [SELW-1:0]     mask_sel,
    input  logic [NPINS-1:0]    mask_wdata,
    output logic [NCLIENTS-1:0] evt_valid,
    output logic [NPINS-1:0]    evt_levels,
    output logic [NPINS-1:0]    evt_changed
);
    logic [CW-1:0]                  ctl_q, ctl_n;
    logic [NPINS-1:0]               dat_q, dat_n;
    logic [NPINS-1:0]               pdir_q, pdir_n;
    logic [NPINS-1:0]               pdat_q, pdat_n;
    logic [NCLIENTS-1:0][NPINS-1:0] mask_q;

    logic [NPINS-1:0] dir_c, pup_c, dir_n, pup_n;
    logic [NPINS-1:0] cur_lv, nxt_lv;
    res_state_t       st;

    always_comb begin
        ctl_n  = ctl_wr ? ctl_wdata : ctl_q;
        dat_n  = dat_wr ? dat_wdata : dat_q;
        pdir_n = per_wr ? per_dir   : pdir_q;
        pdat_n = per_wr ? per_data  : pdat_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q  <= '0;
            dat_q  <= '0;
            pdir_q <= '0;
            pdat_q <= '0;
        end else begin
            ctl_q  <= ctl_n;
            dat_q  <= dat_n;
            pdir_q <= pdir_n;
            pdat_q <= pdat_n;
        end
    end

    for (genvar i = 0; i < NCLIENTS; i++) begin : g_mask
        always_ff @(posedge clk) begin
            if (!rst_n)
                mask_q[i] <= '0;
            else if (mask_wr && (mask_sel == SELW'(i)))
                mask_q[i] <= mask_wdata;
        end
    end

    gpio_ctl_split #(.NPINS(NPINS)) u_split_cur (
        .ctl (ctl_q), .dir (dir_c), .pup (pup_c)
    );
    gpio_ctl_split #(.NPINS(NPINS)) u_split_nxt (
        .ctl (ctl_n), .dir (dir_n), .pup (pup_n)
    );

    gpio_level_resolve #(.NPINS(NPINS)) u_res_cur (
        .cpu_dir (dir_c), .cpu_dat (dat_q),
        .per_dir (pdir_q), .per_dat (pdat_q),
        .pup     (pup_c), .lv      (cur_lv)
    );
    gpio_level_resolve #(.NPINS(NPINS)) u_res_nxt (
        .cpu_dir (dir_n), .cpu_dat (dat_n),
        .per_dir (pdir_n), .per_dat (pdat_n),
        .pup     (pup_n), .lv      (nxt_lv)
    );

    gpio_evt_fsm #(.NPINS(NPINS), .NCLIENTS(NCLIENTS)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_wr      (ctl_wr | dat_wr),
        .per_wr      (per_wr),
        .cur_lv      (cur_lv),
        .nxt_lv      (nxt_lv),
        .mask        (mask_q),
        .st          (st),
        .evt_valid   (evt_valid),
        .evt_levels  (evt_levels),
        .evt_changed (evt_changed)
    );

    assign dat_rdata = cur_lv;
endmodule

// File: rtl/gpio_port_resolver_chk.sv
module gpio_port_resolver_chk
    import gpio_res_pkg::*;
#(
    parameter int NPINS    = 16,
    parameter int NCLIENTS = 4
) (
    input logic                           clk,
    input logic                           rst_n,
    input logic                           ctl_wr,
    input logic                           dat_wr,
    input logic                           per_wr,
    input logic [NPINS-1:0]               dat_rdata,
    input logic [NCLIENTS-1:0]            evt_valid,
    input logic [NPINS-1:0]               evt_levels,
    input logic [NPINS-1:0]               evt_changed,
    input logic [NCLIENTS-1:0][NPINS-1:0] mask_q,
    input res_state_t                     st
);
    // R5: notified levels are the levels now visible on readback
    p_levels_match_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (|evt_valid) |-> (evt_levels == dat_rdata));

    // R5: a CPU write in IDLE reports exactly the pins that moved
    p_bus_diff_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ((ctl_wr || dat_wr) && st == ST_IDLE) |=>
        ((dat_rdata == $past(dat_rdata)) ||
         (evt_changed == (dat_rdata ^ $past(dat_rdata)))));

    // R6: unchanged levels after a CPU write in IDLE give no notification
    p_quiet_same_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((ctl_wr || dat_wr) && st == ST_IDLE) |=>
        ((dat_rdata != $past(dat_rdata)) || (evt_valid == '0)));

    // R7: a notification always carries a non-empty change set
    p_nonempty_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (|evt_valid) |-> (evt_changed != '0));

    for (genvar i = 0; i < NCLIENTS; i++) begin : g_cl
        // R7: client notified only when its mask overlaps the changed pins
        p_mask_hit_r7: assert property (@(posedge clk) disable iff (!rst_n)
            evt_valid[i] |-> (|($past(mask_q[i]) & evt_changed)));
    end

    // R8: lone peripheral update in IDLE enters REEVAL without notifying
    p_enter_reeval_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE && !ctl_wr && !dat_wr && per_wr) |=>
        (st == ST_REEVAL && evt_valid == '0));

    // R10: REEVAL lasts one cycle
    p_leave_reeval_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_REEVAL) |=> (st == ST_IDLE));
endmodule

bind gpio_port_resolver gpio_port_resolver_chk #(
    .NPINS    (NPINS),
    .NCLIENTS (NCLIENTS)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ctl_wr      (ctl_wr),
    .dat_wr      (dat_wr),
    .per_wr      (per_wr),
    .dat_rdata   (dat_rdata),
    .evt_valid   (evt_valid),
    .evt_levels  (evt_levels),
    .evt_changed (evt_changed),
    .mask_q      (mask_q),
    .st          (st)
);

// File: tb/tb_gpio_port_resolver.sv
module tb_gpio_port_resolver;
    localparam int NP = 16;
    localparam int NC = 4;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          ctl_wr;
    logic [31:0]   ctl_wdata;
    logic          dat_wr;
    logic [15:0]   dat_wdata;
    logic [15:0]   dat_rdata;
    logic          per_wr;
    logic [15:0]   per_dir;
    logic [15:0]   per_data;
    logic          mask_wr;
    logic [1:0]    mask_sel;
    logic [15:0]   mask_wdata;
    logic [3:0]    evt_valid;
    logic [15:0]   evt_levels;
    logic [15:0]   evt_changed;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    gpio_port_resolver #(.NPINS(NP), .NCLIENTS(NC)) dut (
        .clk (clk), .rst_n (rst_n),
        .ctl_wr (ctl_wr), .ctl_wdata (ctl_wdata),
        .dat_wr (dat_wr), .dat_wdata (dat_wdata), .dat_rdata (dat_rdata),
        .per_wr (per_wr), .per_dir (per_dir), .per_data (per_data),
        .mask_wr (mask_wr), .mask_sel (mask_sel), .mask_wdata (mask_wdata),
        .evt_valid (evt_valid), .evt_levels (evt_levels), .evt_changed (evt_changed)
    );

    // bench model
    logic [31:0] m_ctl;
    logic [15:0] m_dat, m_pd, m_pv, m_snap, e_lv, e_ch, m_nxt;
    logic [15:0] m_mask [NC];
    logic [3:0]  e_v;
    bit          m_re;

    function automatic logic [15:0] f_res(input logic [31:0] c, input logic [15:0] d,
                                          input logic [15:0] pd, input logic [15:0] pv);
        logic [15:0] dr, pu;
        for (int n = 0; n < 16; n++) begin
            dr[n] = c[2*n];
            pu[n] = c[2*n+1];
        end
        return (dr & d) | (pd & pv) | (~(dr | pd) & pu);
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        m_ctl = '0; m_dat = '0; m_pd = '0; m_pv = '0; m_snap = '0;
        e_lv = '0; e_ch = '0; e_v = '0; m_re = 1'b0; m_nxt = '0;
        for (int i = 0; i < NC; i++) m_mask[i] = '0;
    endtask

    // one clock: drive at negedge, advance model, check at next negedge
    task automatic cyc(input bit cw, input logic [31:0] cd,
                       input bit dw, input logic [15:0] dd,
                       input bit pw, input logic [15:0] pdr, input logic [15:0] pdt,
                       input bit mw, input logic [1:0] ms, input logic [15:0] md);
        logic [15:0] cur, old;
        bit emit;
        ctl_wr = cw; ctl_wdata = cd; dat_wr = dw; dat_wdata = dd;
        per_wr = pw; per_dir = pdr; per_data = pdt;
        mask_wr = mw; mask_sel = ms; mask_wdata = md;
        cur = f_res(m_ctl, m_dat, m_pd, m_pv);
        if (cw) m_ctl = cd;
        if (dw) m_dat = dd;
        if (pw) begin m_pd = pdr; m_pv = pdt; end
        m_nxt = f_res(m_ctl, m_dat, m_pd, m_pv);
        emit = 1'b0; old = cur;
        if (!m_re) begin
            if (cw || dw) emit = 1'b1;
            else if (pw) begin m_snap = cur; m_re = 1'b1; end
        end else begin
            emit = 1'b1; old = m_snap; m_re = 1'b0;
        end
        e_v = '0;
        if (emit && (old != m_nxt)) begin
            e_ch = old ^ m_nxt;
            e_lv = m_nxt;
            for (int i = 0; i < NC; i++) e_v[i] = |(m_mask[i] & e_ch);
        end
        if (mw) m_mask[ms] = md;
        @(posedge clk);
        @(negedge clk);
        chk("R2 readback", {16'h0, dat_rdata}, {16'h0, m_nxt});
        chk("R7 valid", {28'h0, evt_valid}, {28'h0, e_v});
        chk("R5 levels", {16'h0, evt_levels}, {16'h0, e_lv});
        chk("R5 changed", {16'h0, evt_changed}, {16'h0, e_ch});
    endtask

    task automatic idle();
        cyc(0, '0, 0, '0, 0, '0, '0, 0, '0, '0);
    endtask

    task automatic summary();
        $display("  test done: total=%0d bad=%0d", total, bad);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2718));
        rst_n = 1'b0;
        ctl_wr = 0; ctl_wdata = '0; dat_wr = 0; dat_wdata = '0;
        per_wr = 0; per_dir = '0; per_data = '0;
        mask_wr = 0; mask_sel = '0; mask_wdata = '0;
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R4 reset rdata", {16'h0, dat_rdata}, 32'h0);
        chk("R4 reset valid", {28'h0, evt_valid}, 32'h0);
        chk("R4 reset changed", {16'h0, evt_changed}, 32'h0);

        // masks: c0 all, c1 pin0, c2 upper byte, c3 none; mask writes are silent (R7)
        cyc(0, '0, 0, '0, 0, '0, '0, 1, 2'd0, 16'hFFFF);
        cyc(0, '0, 0, '0, 0, '0, '0, 1, 2'd1, 16'h0001);
        cyc(0, '0, 0, '0, 0, '0, '0, 1, 2'd2, 16'hFF00);
        chk("R7 mask write silent", {28'h0, evt_valid}, 32'h0);

        // R1: pull-up bit of pin 0 is control bit 1
        cyc(1, 32'h0000_0002, 0, '0, 0, '0, '0, 0, '0, '0);
        chk("R1 pull-up decode", {16'h0, dat_rdata}, 32'h0001);
        chk("R7 partial clients", {28'h0, evt_valid}, 32'h3);

        // R3 / R6: data to undriven pins has no effect and no event
        cyc(0, '0, 1, 16'h00F0, 0, '0, '0, 0, '0, '0);
        chk("R3 undriven data", {16'h0, dat_rdata}, 32'h0001);
        chk("R6 no event", {28'h0, evt_valid}, 32'h0);

        // R1 / R3: direction bits 8,10,12,14 expose stored data on pins 4..7
        cyc(1, 32'h0000_5502, 0, '0, 0, '0, '0, 0, '0, '0);
        chk("R1 direction decode", {16'h0, dat_rdata}, 32'h00F1);
        chk("R5 changed set", {16'h0, evt_changed}, 32'h00F0);
        chk("R7 only client0", {28'h0, evt_valid}, 32'h1);

        // R8: peripheral update alone
        cyc(0, '0, 0, '0, 1, 16'h0100, 16'h0100, 0, '0, '0);
        chk("R8 no event in REEVAL", {28'h0, evt_valid}, 32'h0);
        idle();
        chk("R8 delayed event", {28'h0, evt_valid}, 32'h5);
        chk("R8 delayed changed", {16'h0, evt_changed}, 32'h0100);

        // R9: peripheral update folded into a CPU write
        cyc(0, '0, 1, 16'h0000, 1, 16'h0000, 16'h0000, 0, '0, '0);
        chk("R9 folded changed", {16'h0, evt_changed}, 32'h01F0);
        chk("R9 folded valid", {28'h0, evt_valid}, 32'h5);
        idle();
        chk("R9 no second event", {28'h0, evt_valid}, 32'h0);

        // R10: CPU write while in REEVAL compares against pre-update snapshot
        cyc(0, '0, 0, '0, 1, 16'h0002, 16'h0002, 0, '0, '0);
        chk("R10 quiet first", {28'h0, evt_valid}, 32'h0);
        cyc(1, 32'h0, 0, '0, 0, '0, '0, 0, '0, '0);
        chk("R10 snapshot diff", {16'h0, evt_changed}, 32'h0003);
        chk("R10 valid", {28'h0, evt_valid}, 32'h3);
        idle();
        chk("R10 back to idle", {28'h0, evt_valid}, 32'h0);

        // constrained random
        for (int k = 0; k < 400; k++) begin
            bit cw, dw, pw, mw;
            cw = ($urandom % 4) == 0;
            dw = ($urandom % 4) == 0;
            pw = ($urandom % 4) == 0;
            mw = ($urandom % 8) == 0;
            cyc(cw, $urandom, dw, 16'($urandom), pw, 16'($urandom), 16'($urandom),
                mw, 2'($urandom), 16'($urandom));
        end

        done = 1'b1;
        summary();
        $finish;
    end
endmodule